// File: doc/BRIEF.md
# Page-Translated DMA Channel Engine

This block runs four DMA channels. Each channel moves device data to or from memory, and every logical address is translated through a single-level page table that sits in memory. Software programs each channel over a simple word-addressed register bus. A channel has a flag word, a byte count and a logical address. Two global words give the base and the byte size of the translation table.

A device starts a burst by raising a request with a channel number, a direction and a byte length. The engine first checks the channel against the request. It then clamps the length to the channel count. For each 4 KiB logical page it reads the page frame from the table through a request/grant memory port. It emits one segment descriptor for each page it touches, giving the physical address and the length. A data mover next to the block consumes these descriptors. After each segment the engine writes back the count and the logical address. At the end it records a terminal-count flag or a fault flag in the channel flag word.

Top module: `pgdma_engine`

## Requirements
- R1: After reset, every register reads 0 and `busy` is 0.
- R2: Register word addresses are: 0 for the table base, 1 for the table limit in bytes, and 4*(c+1)+0/1/2 for the flags, count and logical address of channel c. Other addresses read 0. Only flag bits 0, 1, 8, 9 and 10 are stored, so writing 0xFFFF to a flag word reads back 0x703.
- R3: Flag bit 0 enables the channel. Bit 1 set means the memory-to-device direction. When a request is accepted, bits 8, 9 and 10 are cleared. If bit 0 is 0, or `req_to_dev` differs from bit 1, bit 9 is set and no segment is issued. In that case count and address are unchanged.
- R4: The transfer length is the smaller of `req_len` and the channel count. A count of 0 issues no segment and sets bit 8.
- R5: No segment crosses a 4096-byte page. Each segment length is the smaller of the bytes left in the current page and the bytes left in the request. Segments are issued in ascending logical order.
- R6: The table entry address is (base + (logical address / 4096) * 8) masked to its low 31 bits. The first word of the entry is the frame base. The segment physical address is that frame plus the low 12 bits of the logical address. `mem_req` holds with a stable address until `mem_gnt`.
- R7: If a page index is not less than limit/8, bit 9 is set and the transfer stops. Segments already issued stay counted.
- R8: After each segment, the count drops by the segment length and the logical address rises by it. When all bytes are moved, bit 8 is set.
- R9: `busy` rises in the cycle after a request is accepted and falls at the final flag update. A request presented while `busy` is 1 is ignored.
- R10: A transfer changes the registers of its own channel only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | RA_W (5) | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| req_valid | input | 1 | Device burst request |
| req_chan | input | CH_W (2) | Requested channel |
| req_to_dev | input | 1 | 1 = memory-to-device |
| req_len | input | LEN_W (16) | Requested byte length |
| busy | output | 1 | Transfer in progress |
| mem_req | output | 1 | Table word read request |
| mem_addr | output | 32 | Table word byte address |
| mem_gnt | input | 1 | Grant; read data valid with it |
| mem_rdata | input | 32 | Read data |
| seg_valid | output | 1 | Segment descriptor strobe |
| seg_addr | output | 32 | Segment physical address |
| seg_len | output | PAGE_W+1 (13) | Segment byte length |
| seg_to_dev | output | 1 | Segment direction |

## Verification
The bench builds the engine with its defaults: four channels, 16-bit request lengths and 12-bit page offsets. A single request can therefore span three pages, and a request longer than the count exercises clamping. The table limit is set to 64 bytes, so the table has eight entries and a walk off its end is reached with modest addresses. The table base has bit 31 set, and the memory model returns a poison word for any address above 4 KiB, which exposes a missing mask. The grant latency varies between requests, so the bench can present a second request during a long fetch.

// File: rtl/pgdma_pkg.sv
package pgdma_pkg;

    localparam int WORD_W = 32;

    localparam int FL_EN  = 0;
    localparam int FL_M2D = 1;
    localparam int FL_TC  = 8;
    localparam int FL_MEM = 9;
    localparam int FL_ADR = 10;

    localparam logic [WORD_W-1:0] FLAG_KEEP = 32'h0000_0703;
    localparam logic [WORD_W-1:0] FLAG_CLR  = 32'h0000_0700;
    localparam logic [WORD_W-1:0] ENTRY_MSK = 32'h7FFF_FFFF;
    localparam int ENTRY_SHIFT = 3;

    typedef struct packed {
        logic [WORD_W-1:0] flags;
        logic [WORD_W-1:0] count;
        logic [WORD_W-1:0] laddr;
    } chan_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CHECK,
        ST_WALK,
        ST_FETCH
    } seq_state_t;

endpackage

// File: rtl/pgdma_regs.sv
module pgdma_regs
    import pgdma_pkg::*;
#(
    parameter int NCH  = 4,
    parameter int RA_W = 5,
    parameter int CH_W = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic [RA_W-1:0]      bus_addr,
    input  logic [WORD_W-1:0]    bus_wdata,
    output logic [WORD_W-1:0]    bus_rdata,
    input  logic                 upd_valid,
    input  logic [CH_W-1:0]      upd_chan,
    input  chan_t                upd_rec,
    output logic [WORD_W-1:0]    tbl_base,
    output logic [WORD_W-1:0]    tbl_limit,
    output chan_t [NCH-1:0]      chans
);

    typedef struct packed {
        logic [WORD_W-1:0] base;
        logic [WORD_W-1:0] limit;
        chan_t [NCH-1:0]   ch;
    } rf_t;

    rf_t rf_d, rf_q;
    logic [RA_W-1:0] slot;

    assign slot = bus_addr >> 2;

    always_comb begin
        rf_d = rf_q;
        bus_rdata = '0;
        if (bus_addr == RA_W'(0)) bus_rdata = rf_q.base;
        if (bus_addr == RA_W'(1)) bus_rdata = rf_q.limit;
        for (int c = 0; c < NCH; c++) begin
            if (32'(slot) == c + 1) begin
                case (bus_addr[1:0])
                    2'd0:    bus_rdata = rf_q.ch[c].flags;
                    2'd1:    bus_rdata = rf_q.ch[c].count;
                    2'd2:    bus_rdata = rf_q.ch[c].laddr;
                    default: bus_rdata = '0;
                endcase
            end
        end
        if (bus_wr) begin
            if (bus_addr == RA_W'(0)) rf_d.base  = bus_wdata;
            if (bus_addr == RA_W'(1)) rf_d.limit = bus_wdata;
            for (int c = 0; c < NCH; c++) begin
                if (32'(slot) == c + 1) begin
                    case (bus_addr[1:0])
                        2'd0:    rf_d.ch[c].flags = bus_wdata & FLAG_KEEP;
                        2'd1:    rf_d.ch[c].count = bus_wdata;
                        2'd2:    rf_d.ch[c].laddr = bus_wdata;
                        default: ;
                    endcase
                end
            end
        end
        // sequencer write-back wins over a bus write to the same channel
        if (upd_valid) begin
            rf_d.ch[upd_chan]       = upd_rec;
            rf_d.ch[upd_chan].flags = upd_rec.flags & FLAG_KEEP;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rf_q <= '0;
        else        rf_q <= rf_d;
    end

    assign tbl_base  = rf_q.base;
    assign tbl_limit = rf_q.limit;
    assign chans     = rf_q.ch;

endmodule

// File: rtl/pgdma_seq.sv
module pgdma_seq
    import pgdma_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int CH_W   = 2,
    parameter int LEN_W  = 16,
    parameter int PAGE_W = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [CH_W-1:0]      req_chan,
    input  logic                 req_to_dev,
    input  logic [LEN_W-1:0]     req_len,
    input  chan_t [NCH-1:0]      chans,
    input  logic [WORD_W-1:0]    tbl_base,
    input  logic [WORD_W-1:0]    tbl_limit,
    output logic                 busy,
    output logic                 mem_req,
    output logic [WORD_W-1:0]    mem_addr,
    input  logic                 mem_gnt,
    input  logic [WORD_W-1:0]    mem_rdata,
    output logic                 upd_valid,
    output logic [CH_W-1:0]      upd_chan,
    output chan_t                upd_rec,
    output logic                 seg_valid,
    output logic [WORD_W-1:0]    seg_addr,
    output logic [PAGE_W:0]      seg_len,
    output logic                 seg_to_dev
);

    localparam int SEG_W = PAGE_W + 1;
    localparam logic [SEG_W-1:0] PAGE_BYTES = SEG_W'(1) << PAGE_W;

    typedef struct packed {
        seq_state_t        st;
        logic [CH_W-1:0]   chan;
        logic              to_dev;
        logic [LEN_W-1:0]  remain;
        logic [WORD_W-1:0] laddr;
        logic [WORD_W-1:0] count;
        logic [WORD_W-1:0] flags;
        logic              seg_valid;
        logic [WORD_W-1:0] seg_addr;
        logic [SEG_W-1:0]  seg_len;
    } seq_t;

    seq_t q, d;
    chan_t cur;
    logic [WORD_W-1:0] fl;
    logic [PAGE_W-1:0] off;
    logic [SEG_W-1:0]  room;
    logic [SEG_W-1:0]  slen;
    logic [WORD_W-1:0] idx;
    logic [WORD_W-1:0] idx_lim;

    always_comb begin
        d         = q;
        d.seg_valid = 1'b0;
        upd_valid = 1'b0;
        cur       = chans[q.chan];
        fl        = cur.flags & ~FLAG_CLR;
        off       = q.laddr[PAGE_W-1:0];
        room      = PAGE_BYTES - {1'b0, off};
        if (32'(q.remain) < 32'(room)) slen = SEG_W'(q.remain);
        else                           slen = room;
        idx       = q.laddr >> PAGE_W;
        idx_lim   = tbl_limit >> ENTRY_SHIFT;
        mem_addr  = (tbl_base + (idx << ENTRY_SHIFT)) & ENTRY_MSK;

        case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.st     = ST_CHECK;
                    d.chan   = req_chan;
                    d.to_dev = req_to_dev;
                    d.remain = req_len;
                end
            end
            ST_CHECK: begin
                upd_valid = 1'b1;
                d.count   = cur.count;
                d.laddr   = cur.laddr;
                if (!fl[FL_EN] || (fl[FL_M2D] != q.to_dev)) begin
                    fl[FL_MEM] = 1'b1;
                    d.st       = ST_IDLE;
                end else begin
                    if (32'(q.remain) > cur.count) d.remain = LEN_W'(cur.count);
                    d.st = ST_WALK;
                end
                d.flags = fl;
            end
            ST_WALK: begin
                if (q.remain == '0) begin
                    d.flags[FL_TC] = 1'b1;
                    upd_valid      = 1'b1;
                    d.st           = ST_IDLE;
                end else if (idx >= idx_lim) begin
                    d.flags[FL_MEM] = 1'b1;
                    upd_valid       = 1'b1;
                    d.st            = ST_IDLE;
                end else begin
                    d.st = ST_FETCH;
                end
            end
            ST_FETCH: begin
                if (mem_gnt) begin
                    d.seg_valid = 1'b1;
                    d.seg_addr  = mem_rdata + 32'(off);
                    d.seg_len   = slen;
                    d.remain    = q.remain - LEN_W'(slen);
                    d.laddr     = q.laddr + 32'(slen);
                    d.count     = q.count - 32'(slen);
                    upd_valid   = 1'b1;
                    d.st        = ST_WALK;
                end
            end
            default: d.st = ST_IDLE;
        endcase

        upd_rec.flags = d.flags;
        upd_rec.count = d.count;
        upd_rec.laddr = d.laddr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign busy       = (q.st != ST_IDLE);
    assign mem_req    = (q.st == ST_FETCH);
    assign upd_chan   = q.chan;
    assign seg_valid  = q.seg_valid;
    assign seg_addr   = q.seg_addr;
    assign seg_len    = q.seg_len;
    assign seg_to_dev = q.to_dev;

endmodule

// File: rtl/pgdma_engine.sv
module pgdma_engine
    import pgdma_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int LEN_W  = 16,
    parameter int PAGE_W = 12,
    localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int RA_W  = $clog2(4 * (NCH + 1))
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic [RA_W-1:0]      reg_addr,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    input  logic                 req_valid,
    input  logic [CH_W-1:0]      req_chan,
    input  logic                 req_to_dev,
    input  logic [LEN_W-1:0]     req_len,
    output logic                 busy,
    output logic                 mem_req,
    output logic [31:0]          mem_addr,
    input  logic                 mem_gnt,
    input  logic [31:0]          mem_rdata,
    output logic                 seg_valid,
    output logic [31:0]          seg_addr,
    output logic [PAGE_W:0]      seg_len,
    output logic                 seg_to_dev
);

    chan_t [NCH-1:0]   chans;
    chan_t             upd_rec;
    logic              upd_valid;
    logic [CH_W-1:0]   upd_chan;
    logic [WORD_W-1:0] tbl_base;
    logic [WORD_W-1:0] tbl_limit;

    pgdma_regs #(.NCH(NCH), .RA_W(RA_W), .CH_W(CH_W)) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (reg_wr),
        .bus_addr  (reg_addr),
        .bus_wdata (reg_wdata),
        .bus_rdata (reg_rdata),
        .upd_valid (upd_valid),
        .upd_chan  (upd_chan),
        .upd_rec   (upd_rec),
        .tbl_base  (tbl_base),
        .tbl_limit (tbl_limit),
        .chans     (chans)
    );

    pgdma_seq #(.NCH(NCH), .CH_W(CH_W), .LEN_W(LEN_W), .PAGE_W(PAGE_W)) i_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_chan   (req_chan),
        .req_to_dev (req_to_dev),
        .req_len    (req_len),
        .chans      (chans),
        .tbl_base   (tbl_base),
        .tbl_limit  (tbl_limit),
        .busy       (busy),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_gnt    (mem_gnt),
        .mem_rdata  (mem_rdata),
        .upd_valid  (upd_valid),
        .upd_chan   (upd_chan),
        .upd_rec    (upd_rec),
        .seg_valid  (seg_valid),
        .seg_addr   (seg_addr),
        .seg_len    (seg_len),
        .seg_to_dev (seg_to_dev)
    );

endmodule

// File: rtl/pgdma_checker.sv
module pgdma_checker #(
    parameter int PAGE_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              busy,
    input logic              mem_req,
    input logic [31:0]       mem_addr,
    input logic              mem_gnt,
    input logic              seg_valid,
    input logic [31:0]       seg_addr,
    input logic [PAGE_W:0]   seg_len
);

    localparam logic [31:0] PAGE_BYTES = 32'(1) << PAGE_W;

    assert_seg_in_page_R5: assert property (@(posedge clk) disable iff (!rst_n)
        seg_valid |-> ((32'(seg_addr[PAGE_W-1:0]) + 32'(seg_len) <= PAGE_BYTES) && (seg_len != '0)));

    assert_entry_masked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !mem_addr[31]);

    assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr)));

    assert_seg_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_valid || mem_req) |-> busy);

    assert_accept_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid) |=> busy);

endmodule

bind pgdma_engine pgdma_checker #(.PAGE_W(PAGE_W)) i_pgdma_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .busy      (busy),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .mem_gnt   (mem_gnt),
    .seg_valid (seg_valid),
    .seg_addr  (seg_addr),
    .seg_len   (seg_len)
);

// File: tb/test_pgdma_engine.sv
module test_pgdma_engine;

    localparam int NCH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        req_valid = 1'b0;
    logic [1:0]  req_chan = '0;
    logic        req_to_dev = 1'b0;
    logic [15:0] req_len = '0;
    logic        busy;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_gnt;
    logic [31:0] mem_rdata;
    logic        seg_valid;
    logic [31:0] seg_addr;
    logic [12:0] seg_len;
    logic        seg_to_dev;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    pgdma_engine i_pgdma_engine (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
        .req_chan(req_chan), .req_to_dev(req_to_dev), .req_len(req_len),
        .busy(busy), .mem_req(mem_req), .mem_addr(mem_addr), .mem_gnt(mem_gnt),
        .mem_rdata(mem_rdata), .seg_valid(seg_valid), .seg_addr(seg_addr),
        .seg_len(seg_len), .seg_to_dev(seg_to_dev)
    );

    // memory model: 4 KiB of words, poison above
    logic [31:0] mem [1024];
    logic [3:0]  wcnt = '0;
    int          mem_delay = 0;

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        if (a[31:12] == '0) return mem[a[11:2]];
        return 32'hBAD0_0000;
    endfunction

    assign mem_gnt   = mem_req && (32'(wcnt) >= mem_delay);
    assign mem_rdata = mem_word(mem_addr);

    always @(posedge clk) begin
        if (mem_req && !mem_gnt) wcnt <= wcnt + 4'd1;
        else                     wcnt <= '0;
    end

    // scoreboard
    typedef struct {
        logic [31:0] addr;
        logic [12:0] len;
        logic        to_dev;
    } seg_item_t;

    seg_item_t exp_q[$];

    always @(negedge clk) begin
        if (rst_n && seg_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                failures++;
                $display("FAIL R5 unexpected segment addr=%h len=%h expected none", seg_addr, seg_len);
            end else begin
                seg_item_t e;
                e = exp_q.pop_front();
                if (seg_addr !== e.addr || seg_len !== e.len || seg_to_dev !== e.to_dev) begin
                    failures++;
                    $display("FAIL R6 segment actual addr=%h len=%h dir=%b expected addr=%h len=%h dir=%b",
                             seg_addr, seg_len, seg_to_dev, e.addr, e.len, e.to_dev);
                end
            end
        end
    end

    // model copies of the registers
    logic [31:0] m_base = '0, m_limit = '0;
    logic [31:0] m_flags [NCH];
    logic [31:0] m_count [NCH];
    logic [31:0] m_addr  [NCH];

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 5'(a); reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
        if (a == 0) m_base = v;
        else if (a == 1) m_limit = v;
        else begin
            int c = a / 4 - 1;
            if (a % 4 == 0) m_flags[c] = v & 32'h703;
            if (a % 4 == 1) m_count[c] = v;
            if (a % 4 == 2) m_addr[c]  = v;
        end
    endtask

    task automatic rd(input int a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        reg_addr = 5'(a);
        #1;
        check(tag, reg_rdata, exp);
    endtask

    task automatic check_chan(input int c, input string tag);
        rd(4 * (c + 1) + 0, m_flags[c], {tag, " flags"});
        rd(4 * (c + 1) + 1, m_count[c], {tag, " count"});
        rd(4 * (c + 1) + 2, m_addr[c],  {tag, " addr"});
    endtask

    // expected behaviour from the requirements
    task automatic model(input int c, input bit td, input int len);
        logic [31:0] f, a, cnt, rem, idx, ea, sl, off;
        f = m_flags[c] & ~32'h700;
        if (!f[0] || (f[1] != td)) begin
            f[9] = 1'b1;
        end else begin
            a = m_addr[c]; cnt = m_count[c];
            rem = (32'(len) > cnt) ? cnt : 32'(len);
            while (1) begin
                if (rem == 0) begin f[8] = 1'b1; break; end
                idx = a >> 12;
                if (idx >= (m_limit >> 3)) begin f[9] = 1'b1; break; end
                ea  = (m_base + idx * 8) & 32'h7FFF_FFFF;
                off = a & 32'hFFF;
                sl  = 32'd4096 - off;
                if (sl > rem) sl = rem;
                exp_q.push_back('{addr: mem_word(ea) + off, len: 13'(sl), to_dev: td});
                a += sl; cnt -= sl; rem -= sl;
            end
            m_addr[c] = a; m_count[c] = cnt;
        end
        m_flags[c] = f;
    endtask

    task automatic run_req(input int c, input bit td, input int len, input int dly,
                           input bit intrude, input string tag);
        mem_delay = dly;
        model(c, td, len);
        @(negedge clk);
        req_valid = 1'b1; req_chan = 2'(c); req_to_dev = td; req_len = 16'(len);
        @(negedge clk);
        req_valid = 1'b0;
        check({tag, " R9 busy after accept"}, 32'(busy), 32'd1);
        if (intrude) begin
            req_valid = 1'b1; req_chan = 2'd2; req_to_dev = 1'b0; req_len = 16'h40;
            @(negedge clk);
            @(negedge clk);
            req_valid = 1'b0;
        end
        while (busy) @(negedge clk);
        @(negedge clk);
        check({tag, " R9 busy stays low"}, 32'(busy), 32'd0);
        @(negedge clk);
        check({tag, " R5 all segments seen"}, 32'(exp_q.size()), 32'd0);
        exp_q.delete();
        check_chan(c, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL R9 watchdog expired actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
        for (int k = 0; k < 16; k++) begin
            mem[(32'h100 >> 2) + 2 * k]     = 32'h0040_0000 + 32'(k) * 32'h0001_1000;
            mem[(32'h100 >> 2) + 2 * k + 1] = 32'hDEAD_0000 + 32'(k);
        end
        for (int c = 0; c < NCH; c++) begin
            m_flags[c] = '0; m_count[c] = '0; m_addr[c] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 busy", 32'(busy), 32'd0);
        rd(0, 32'h0, "R1 base");
        rd(1, 32'h0, "R1 limit");
        for (int c = 0; c < NCH; c++) check_chan(c, "R1");

        // R2 map, flag mask, unused address
        wr(0, 32'h8000_0100);
        wr(1, 32'h0000_0040);
        rd(0, 32'h8000_0100, "R2 base");
        rd(1, 32'h0000_0040, "R2 limit");
        wr(4, 32'h0000_FFFF);
        rd(4, 32'h0000_0703, "R2 flag mask");
        wr(3, 32'h1234_5678);
        rd(3, 32'h0, "R2 unused address");

        // R5 R6 R8: three pages, crossing boundaries
        wr(4, 32'h1); wr(5, 32'h3000); wr(6, 32'h0F00);
        run_req(0, 1'b0, 16'h1200, 1, 1'b0, "R8 ch0 multi-page");

        // R4 clamp, then zero count
        wr(8, 32'h3); wr(9, 32'h80); wr(10, 32'h2010);
        run_req(1, 1'b1, 16'h500, 0, 1'b0, "R4 ch1 clamp");
        run_req(1, 1'b1, 16'h5, 2, 1'b0, "R4 ch1 zero count");

        // R3 direction mismatch and disabled channel
        wr(12, 32'h501); wr(13, 32'h100); wr(14, 32'h0);
        run_req(2, 1'b1, 16'h20, 0, 1'b0, "R3 ch2 mismatch");
        wr(16, 32'h0); wr(17, 32'h100); wr(18, 32'h40);
        run_req(3, 1'b0, 16'h20, 0, 1'b0, "R3 ch3 disabled");

        // R7 walk past the table limit
        wr(16, 32'h1); wr(17, 32'h0001_0000); wr(18, 32'h6800);
        run_req(3, 1'b0, 16'h3000, 2, 1'b0, "R7 ch3 limit");

        // R9 request while busy ignored (ch2 would otherwise run)
        run_req(0, 1'b0, 16'h10, 3, 1'b1, "R9 ch0 intrude");
        check_chan(2, "R9 ch2 untouched");

        // R10 other channels untouched
        check_chan(1, "R10 ch1");
        check_chan(3, "R10 ch3");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule